// File: doc/BRIEF.md
# Prioritized Interrupt Distributor with Acknowledge

This block is a memory-mapped interrupt controller for one processor with a parameterized number of interrupt lines (64 by default). Each interrupt has an enable bit, a pending bit and an active bit. Each of these bits has its own write-one-to-set address and its own write-one-to-clear address, so software can change single bits without a read-modify-write. Each interrupt also has an 8-bit priority, where a smaller value is more urgent, and a 2-bit trigger configuration.

Every cycle the block picks the most urgent interrupt that is enabled, pending and not active. It raises the request output when that interrupt clears the priority mask and can preempt the running priority. The running priority is computed from the active set, and its low bits are ignored according to a binary point setting.

The processor claims the interrupt by reading the acknowledge register. That read moves the interrupt from pending to active. The processor finishes the interrupt by writing its ID to the end-of-interrupt register. IDs 0 to 15 are software-generated: they become pending only through a dedicated generate register. The remaining IDs come from the `irq_lines` inputs, and each of those is either level-sensitive or edge-triggered.

Top module: `irq_prio_distributor`

## Requirements
- R1: After reset, all enable, pending and active bits are 0. Both control bits are 0, the priority mask is 0x00 and the binary point is 2. Reading the running priority returns 0xFF, `irq_o` is low and reading the acknowledge register returns 1023.
- R2: A 1 written at bit b of address 0x100+4w sets the enable bit of ID 32w+b. A 1 written at bit b of address 0x180+4w clears it. Zero bits have no effect. A read of either address returns the enable bits of that word.
- R3: Addresses 0x200+4w (set) and 0x280+4w (clear) control the pending bits in the same way, and reads return the pending bits. IDs 0 to 15 are not changed by these writes or by `irq_lines[15:0]`.
- R4: A write to 0x01C sets the pending bit of the ID given in wdata[3:0], which is in the range 0 to 15.
- R5: Byte j of the word at 0x400+4k is the priority of ID 4k+j. Bits [2j+1:2j] of the word at 0x800+4k are the configuration of ID 16k+j. The candidate is the enabled, pending, non-active ID with the smallest priority value. When two candidates share that value, the lower ID wins.
- R6: `irq_o` is high only when all of these hold: bit 0 of 0x000 (global enable) is 1, bit 0 of 0x004 (processor enable) is 1, a candidate exists, the candidate's priority is strictly below the mask at 0x008[7:0], and the candidate's group priority is strictly below that of the running priority.
- R7: A read of 0x010 while `irq_o` is high returns the candidate ID in bits [9:0] and 0 in bits [12:10]. In the same cycle it clears that ID's pending bit and sets its active bit.
- R8: A read of 0x010 while `irq_o` is low returns 1023 and changes no state.
- R9: Writing an ID below the number of lines to 0x014 (wdata[9:0]) clears that ID's active bit. Any other value changes nothing.
- R10: Address 0x018 is read-only. It returns the smallest priority value among the active IDs, or 0xFF when no ID is active.
- R11: The binary point at 0x00C[2:0] stores a written value below 2 as 2. When comparing against the running priority, both values have their low (binary point + 1) bits ignored.
- R12: When the upper configuration bit is 0, the line is level-sensitive. A high input keeps setting pending whenever the ID is not active, including in the cycles after end-of-interrupt. When the upper bit is 1, the line is edge-triggered and pending is set only on a 0-to-1 transition of the input.
- R13: Addresses 0x300+4w (set) and 0x380+4w (clear) control the active bits with write-one semantics, and reads return the active bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (acknowledge side effect) |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_lines | input | NUM_IRQ | Interrupt inputs, synchronous to clk; bits 0 to 15 unused |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that reads and writes never happen in the same cycle. They also assume that `irq_lines` is already synchronous to `clk`, and that an end-of-interrupt write never coincides with an acknowledge of the same ID. The stimulus drives all inputs on the falling edge and keeps each bus access to one strobe for one cycle, with an idle cycle between accesses. Line inputs change only between accesses. Every acknowledge in the bench is paired with a later end-of-interrupt or a clear-active write, so active bits never pile up unintentionally.

// File: rtl/ipd_pkg.sv
package ipd_pkg;
   localparam int ADDR_W  = 12;
   localparam int PRIO_W  = 8;
   localparam int NUM_SGI = 16;

   localparam logic [9:0] SPURIOUS_ID = 10'd1023;
   localparam logic [2:0] BPR_FLOOR   = 3'd2;

   localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h000;
   localparam logic [ADDR_W-1:0] OFS_CPUCTRL = 12'h004;
   localparam logic [ADDR_W-1:0] OFS_PMASK   = 12'h008;
   localparam logic [ADDR_W-1:0] OFS_BINPT   = 12'h00C;
   localparam logic [ADDR_W-1:0] OFS_ACK     = 12'h010;
   localparam logic [ADDR_W-1:0] OFS_EOI     = 12'h014;
   localparam logic [ADDR_W-1:0] OFS_RUNPRI  = 12'h018;
   localparam logic [ADDR_W-1:0] OFS_SGI     = 12'h01C;

   // bitmap region code = bus_addr[11:7]
   typedef enum logic [4:0] {
      RG_SETEN   = 5'd2,
      RG_CLREN   = 5'd3,
      RG_SETPEND = 5'd4,
      RG_CLRPEND = 5'd5,
      RG_SETACT  = 5'd6,
      RG_CLRACT  = 5'd7
   } bm_region_e;
endpackage

// File: rtl/ipd_line_capture.sv
module ipd_line_capture #(
   parameter int N = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines,
   output logic [N-1:0] rise
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lines;
   end

   assign rise = lines & ~prev_q;
endmodule

// File: rtl/ipd_min_select.sv
module ipd_min_select #(
   parameter int N  = 64,
   parameter int W  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]   req,
   input  logic [N*W-1:0] key,
   output logic           found,
   output logic [IW-1:0]  idx,
   output logic [W-1:0]   min_key
);
   // ascending scan with strict compare: lowest index wins ties
   always_comb begin
      found   = 1'b0;
      idx     = '0;
      min_key = '1;
      for (int i = 0; i < N; i++) begin
         if (req[i] && (!found || key[i*W +: W] < min_key)) begin
            found   = 1'b1;
            idx     = IW'(i);
            min_key = key[i*W +: W];
         end
      end
   end
endmodule

// File: rtl/irq_prio_distributor.sv
module irq_prio_distributor
   import ipd_pkg::*;
#(
   parameter int NUM_IRQ = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_IRQ-1:0] irq_lines,
   output logic               irq_o
);
   localparam int NUM_WORDS = NUM_IRQ / 32;
   localparam int IDX_W     = $clog2(NUM_IRQ);
   localparam int NUM_EXT   = NUM_IRQ - NUM_SGI;

   if (NUM_IRQ % 32 != 0 || NUM_IRQ < 32 || NUM_IRQ > 992) begin : g_bad_num_irq
      $error("NUM_IRQ must be a multiple of 32 between 32 and 992");
   end

   // ---------------- decode ----------------
   logic [4:0] bm_word;
   logic [7:0] pr_word;
   logic [5:0] cf_word;
   logic w_seten, w_clren, w_setpend, w_clrpend, w_setact, w_clract;
   logic w_prio, w_cfg, sgi_wr, eoi_wr, ack_rd, ack_fire;

   assign bm_word   = bus_addr[6:2];
   assign pr_word   = bus_addr[9:2];
   assign cf_word   = bus_addr[7:2];
   assign w_seten   = bus_wr && bus_addr[11:7] == RG_SETEN;
   assign w_clren   = bus_wr && bus_addr[11:7] == RG_CLREN;
   assign w_setpend = bus_wr && bus_addr[11:7] == RG_SETPEND;
   assign w_clrpend = bus_wr && bus_addr[11:7] == RG_CLRPEND;
   assign w_setact  = bus_wr && bus_addr[11:7] == RG_SETACT;
   assign w_clract  = bus_wr && bus_addr[11:7] == RG_CLRACT;
   assign w_prio    = bus_wr && bus_addr[11:10] == 2'b01;
   assign w_cfg     = bus_wr && bus_addr[11:8] == 4'h8;
   assign sgi_wr    = bus_wr && bus_addr == OFS_SGI;
   assign eoi_wr    = bus_wr && bus_addr == OFS_EOI;
   assign ack_rd    = bus_rd && bus_addr == OFS_ACK;

   // ---------------- control registers ----------------
   logic              gen_en_q, cpu_en_q;
   logic [PRIO_W-1:0] pmask_q;
   logic [2:0]        bpr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gen_en_q <= 1'b0;
         cpu_en_q <= 1'b0;
         pmask_q  <= '0;
         bpr_q    <= BPR_FLOOR;
      end else if (bus_wr) begin
         if (bus_addr == OFS_CTRL)    gen_en_q <= bus_wdata[0];
         if (bus_addr == OFS_CPUCTRL) cpu_en_q <= bus_wdata[0];
         if (bus_addr == OFS_PMASK)   pmask_q  <= bus_wdata[PRIO_W-1:0];
         if (bus_addr == OFS_BINPT)
            bpr_q <= (bus_wdata[2:0] < BPR_FLOOR) ? BPR_FLOOR : bus_wdata[2:0];
      end
   end

   // ---------------- per-interrupt state ----------------
   logic [NUM_IRQ-1:0]        en_vec, pend_vec, act_vec;
   logic [NUM_IRQ*PRIO_W-1:0] pri_flat;
   logic [NUM_IRQ*2-1:0]      cfg_flat;
   logic [NUM_EXT-1:0]        line_rise;
   logic                      cand_found, run_found;
   logic [IDX_W-1:0]          cand_idx, run_idx;
   logic [PRIO_W-1:0]         cand_pri, run_pri;
   logic                      irq_req;
   logic                      unused_sgi_lines;

   assign unused_sgi_lines = ^{irq_lines[NUM_SGI-1:0], run_found, run_idx};

   ipd_line_capture #(.N(NUM_EXT)) u_capture (
      .clk   (clk),
      .rst_n (rst_n),
      .lines (irq_lines[NUM_IRQ-1:NUM_SGI]),
      .rise  (line_rise)
   );

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
      localparam int WD = g / 32;
      localparam int BT = g % 32;
      localparam int PW = g / 4;
      localparam int PB = g % 4;
      localparam int CW = g / 16;
      localparam int CB = g % 16;

      logic              hit_bm, bit_wr, ack_me, eoi_me;
      logic              en_q, pend_q, act_q, pend_d, act_d;
      logic [PRIO_W-1:0] pri_q;
      logic [1:0]        cfg_q;

      assign hit_bm = (bm_word == 5'(WD));
      assign bit_wr = bus_wdata[BT];
      assign ack_me = ack_fire && (cand_idx == IDX_W'(g));
      assign eoi_me = eoi_wr && (bus_wdata[9:0] == 10'(g));

      always_comb begin
         act_d = act_q;
         if (w_setact && hit_bm && bit_wr) act_d = 1'b1;
         if (w_clract && hit_bm && bit_wr) act_d = 1'b0;
         if (eoi_me)                       act_d = 1'b0;
         if (ack_me)                       act_d = 1'b1;
      end

      if (g < NUM_SGI) begin : g_sgi
         always_comb begin
            pend_d = pend_q;
            if (sgi_wr && bus_wdata[3:0] == 4'(g)) pend_d = 1'b1;
            if (ack_me)                            pend_d = 1'b0;
         end
      end else begin : g_ext
         logic hw_set;
         assign hw_set = cfg_q[1] ? line_rise[g-NUM_SGI]
                                  : (irq_lines[g] && !act_q && !ack_me);
         always_comb begin
            pend_d = pend_q;
            if (w_setpend && hit_bm && bit_wr) pend_d = 1'b1;
            if (w_clrpend && hit_bm && bit_wr) pend_d = 1'b0;
            if (ack_me)                        pend_d = 1'b0;
            if (hw_set)                        pend_d = 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
            act_q  <= 1'b0;
            pri_q  <= '0;
            cfg_q  <= '0;
         end else begin
            if (w_seten && hit_bm && bit_wr)      en_q <= 1'b1;
            else if (w_clren && hit_bm && bit_wr) en_q <= 1'b0;
            pend_q <= pend_d;
            act_q  <= act_d;
            if (w_prio && pr_word == 8'(PW)) pri_q <= bus_wdata[PB*8 +: 8];
            if (w_cfg && cf_word == 6'(CW))  cfg_q <= bus_wdata[CB*2 +: 2];
         end
      end

      assign en_vec[g]                  = en_q;
      assign pend_vec[g]                = pend_q;
      assign act_vec[g]                 = act_q;
      assign pri_flat[g*PRIO_W +: PRIO_W] = pri_q;
      assign cfg_flat[g*2 +: 2]         = cfg_q;
   end

   // ---------------- selection ----------------
   ipd_min_select #(.N(NUM_IRQ), .W(PRIO_W)) u_cand_sel (
      .req     (en_vec & pend_vec & ~act_vec),
      .key     (pri_flat),
      .found   (cand_found),
      .idx     (cand_idx),
      .min_key (cand_pri)
   );

   ipd_min_select #(.N(NUM_IRQ), .W(PRIO_W)) u_run_sel (
      .req     (act_vec),
      .key     (pri_flat),
      .found   (run_found),
      .idx     (run_idx),
      .min_key (run_pri)
   );

   logic [PRIO_W-1:0] gmask;
   assign gmask    = 8'hFF << ({1'b0, bpr_q} + 4'd1);
   assign irq_req  = gen_en_q && cpu_en_q && cand_found && (cand_pri < pmask_q)
                     && ((cand_pri & gmask) < (run_pri & gmask));
   assign irq_o    = irq_req;
   assign ack_fire = ack_rd && irq_req;

   // ---------------- read mux ----------------
   always_comb begin
      logic [NUM_IRQ-1:0] sel_vec;
      bus_rdata = '0;
      case (bus_addr[11:8])
         4'h0: begin
            case (bus_addr)
               OFS_CTRL:    bus_rdata[0] = gen_en_q;
               OFS_CPUCTRL: bus_rdata[0] = cpu_en_q;
               OFS_PMASK:   bus_rdata[PRIO_W-1:0] = pmask_q;
               OFS_BINPT:   bus_rdata[2:0] = bpr_q;
               OFS_ACK:     bus_rdata[9:0] = irq_req ? 10'(cand_idx) : SPURIOUS_ID;
               OFS_RUNPRI:  bus_rdata[PRIO_W-1:0] = run_pri;
               default:     bus_rdata = '0;
            endcase
         end
         4'h1, 4'h2, 4'h3: begin
            case (bus_addr[9:8])
               2'd1:    sel_vec = en_vec;
               2'd2:    sel_vec = pend_vec;
               default: sel_vec = act_vec;
            endcase
            for (int w = 0; w < NUM_WORDS; w++)
               if (bm_word == 5'(w)) bus_rdata = sel_vec[w*32 +: 32];
         end
         4'h4, 4'h5, 4'h6, 4'h7: begin
            for (int i = 0; i < NUM_IRQ; i++)
               if (pr_word == 8'(i/4)) bus_rdata[(i%4)*8 +: 8] = pri_flat[i*PRIO_W +: PRIO_W];
         end
         4'h8: begin
            for (int i = 0; i < NUM_IRQ; i++)
               if (cf_word == 6'(i/16)) bus_rdata[(i%16)*2 +: 2] = cfg_flat[i*2 +: 2];
         end
         default: bus_rdata = '0;
      endcase
   end

   // ---------------- assertions ----------------
   logic [IDX_W-1:0] eoi_idx;
   assign eoi_idx = bus_wdata[IDX_W-1:0];

   assert_ack_activates_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire |=> act_vec[$past(cand_idx)]);

   assert_eoi_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && bus_wdata[9:0] < 10'(NUM_IRQ) && !ack_fire && !w_setact)
      |=> !act_vec[$past(eoi_idx)]);

   assert_bpr_floor_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bpr_q >= BPR_FLOOR);

   assert_sgi_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_vec[NUM_SGI-1:0] & ~$past(pend_vec[NUM_SGI-1:0]))) |-> $past(sgi_wr));

   assert_irq_below_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (cand_pri < pmask_q && gen_en_q && cpu_en_q));

   assert_idle_runpri_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (act_vec == '0) |-> (run_pri == 8'hFF));

   assert_spurious_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !irq_o) |=> (act_vec == $past(act_vec)));
endmodule

// File: tb/irq_prio_distributor_bench.sv
module irq_prio_distributor_bench;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NIRQ = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_wr = 1'b0;
   logic            bus_rd = 1'b0;
   logic [11:0]     bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NIRQ-1:0] irq_lines = '0;
   logic            irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_prio_distributor #(.NUM_IRQ(NIRQ)) u_irq_prio_distributor (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_lines (irq_lines),
      .irq_o     (irq_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
      check(tag, d, exp);
   endtask

   task automatic irq_check(input string tag, input logic exp);
      @(negedge clk);
      #1 check(tag, {31'd0, irq_o}, {31'd0, exp});
   endtask

   task automatic t_reset;
      irq_check("R1 irq low", 1'b0);
      rd_check("R1 ctrl", 12'h000, 32'h0);
      rd_check("R1 pmask", 12'h008, 32'h0);
      rd_check("R1 binpt", 12'h00C, 32'h2);
      rd_check("R1 runpri", 12'h018, 32'hFF);
      rd_check("R1 pending", 12'h204, 32'h0);
      rd_check("R1 R8 ack spurious", 12'h010, 32'd1023);
   endtask

   task automatic t_enable;
      wr(12'h104, 32'h0000_0005);
      rd_check("R2 set read", 12'h104, 32'h5);
      rd_check("R2 clr addr read", 12'h184, 32'h5);
      wr(12'h184, 32'h0000_0001);
      rd_check("R2 clear", 12'h104, 32'h4);
      wr(12'h184, 32'hFFFF_FFFF);
      rd_check("R2 all clear", 12'h104, 32'h0);
   endtask

   task automatic t_pend_regs;
      wr(12'h200, 32'hFFFF_FFFF);
      rd_check("R3 sgi bits immune to set", 12'h200, 32'hFFFF_0000);
      wr(12'h280, 32'h000F_0000);
      rd_check("R3 clear pending", 12'h200, 32'hFFF0_0000);
      wr(12'h280, 32'hFFFF_FFFF);
      rd_check("R3 all cleared", 12'h200, 32'h0);
   endtask

   task automatic t_sgi;
      wr(12'h000, 32'h1);
      wr(12'h004, 32'h1);
      wr(12'h008, 32'hFF);
      wr(12'h100, 32'h20);
      wr(12'h01C, 32'h5);
      rd_check("R4 sgi generate", 12'h200, 32'h20);
      wr(12'h280, 32'h20);
      rd_check("R3 sgi immune to clear", 12'h200, 32'h20);
      @(negedge clk); irq_lines[3] = 1'b1;
      repeat (3) @(negedge clk);
      irq_lines[3] = 1'b0;
      rd_check("R3 sgi line ignored", 12'h200, 32'h20);
      irq_check("R6 sgi raises irq", 1'b1);
      rd_check("R7 ack sgi", 12'h010, 32'd5);
      rd_check("R7 pending cleared", 12'h200, 32'h0);
      rd_check("R7 active set", 12'h300, 32'h20);
      rd_check("R10 runpri zero", 12'h018, 32'h0);
      wr(12'h014, 32'd5);
      rd_check("R9 eoi clears", 12'h300, 32'h0);
      wr(12'h180, 32'h20);
   endtask

   task automatic t_priority;
      wr(12'h008, 32'hF0);
      wr(12'h428, 32'h0000_4080);
      wr(12'h42C, 32'h0000_4000);
      rd_check("R5 prio readback", 12'h428, 32'h0000_4080);
      wr(12'h104, 32'h0000_2300);
      wr(12'h204, 32'h0000_2300);
      irq_check("R6 irq high", 1'b1);
      rd_check("R5 R7 tie lowest id", 12'h010, 32'd41);
      rd_check("R7 pend after ack", 12'h204, 32'h2100);
      rd_check("R7 active after ack", 12'h304, 32'h200);
      rd_check("R10 runpri", 12'h018, 32'h40);
      irq_check("R6 equal group blocks", 1'b0);
      rd_check("R8 spurious while blocked", 12'h010, 32'd1023);
      rd_check("R8 pending kept", 12'h204, 32'h2100);
      rd_check("R8 active kept", 12'h304, 32'h200);
      wr(12'h014, 32'd41);
      rd_check("R10 runpri idle", 12'h018, 32'hFF);
      rd_check("R5 next candidate", 12'h010, 32'd45);
      irq_check("R6 lower urgency no preempt", 1'b0);
      wr(12'h014, 32'd45);
      rd_check("R5 last candidate", 12'h010, 32'd40);
      wr(12'h014, 32'd40);
      rd_check("R9 all inactive", 12'h304, 32'h0);
      wr(12'h204, 32'h100);
      wr(12'h008, 32'h80);
      irq_check("R6 mask strict", 1'b0);
      wr(12'h008, 32'h81);
      irq_check("R6 mask pass", 1'b1);
      wr(12'h000, 32'h0);
      irq_check("R6 global off", 1'b0);
      wr(12'h000, 32'h1);
      wr(12'h004, 32'h0);
      irq_check("R6 cpu off", 1'b0);
      wr(12'h004, 32'h1);
      wr(12'h284, 32'h100);
      wr(12'h184, 32'h2300);
      wr(12'h008, 32'hFF);
   endtask

   task automatic t_bpr;
      wr(12'h430, 32'h4048_0000);
      wr(12'h104, 32'h000C_0000);
      wr(12'h204, 32'h0004_0000);
      rd_check("R7 ack id50", 12'h010, 32'd50);
      rd_check("R10 runpri 0x48", 12'h018, 32'h48);
      wr(12'h204, 32'h0008_0000);
      irq_check("R11 bpr2 preempts", 1'b1);
      wr(12'h00C, 32'h3);
      rd_check("R11 bpr 3", 12'h00C, 32'h3);
      irq_check("R11 bpr3 same group", 1'b0);
      wr(12'h00C, 32'h0);
      rd_check("R11 clamp", 12'h00C, 32'h2);
      irq_check("R11 clamp preempts", 1'b1);
      wr(12'h384, 32'h0004_0000);
      wr(12'h284, 32'h0008_0000);
      wr(12'h184, 32'h000C_0000);
      rd_check("R13 clear active", 12'h304, 32'h0);
   endtask

   task automatic t_active;
      wr(12'h420, 32'h0000_2200);
      wr(12'h304, 32'h2);
      rd_check("R13 set active", 12'h304, 32'h2);
      rd_check("R10 runpri 0x22", 12'h018, 32'h22);
      wr(12'h014, 32'd97);
      rd_check("R9 alias ignored", 12'h304, 32'h2);
      wr(12'h014, 32'd33);
      rd_check("R9 eoi 33", 12'h304, 32'h0);
      rd_check("R10 runpri back", 12'h018, 32'hFF);
      wr(12'h304, 32'h2);
      wr(12'h384, 32'h2);
      rd_check("R13 clear", 12'h304, 32'h0);
   endtask

   task automatic t_level_edge;
      wr(12'h80C, 32'h0800_0000);
      rd_check("R5 cfg readback", 12'h80C, 32'h0800_0000);
      @(negedge clk); irq_lines[60] = 1'b1; irq_lines[61] = 1'b1;
      repeat (3) @(negedge clk);
      rd_check("R12 both pend", 12'h204, 32'h3000_0000);
      wr(12'h284, 32'h3000_0000);
      rd_check("R12 level re-pends edge not", 12'h204, 32'h1000_0000);
      wr(12'h104, 32'h1000_0000);
      rd_check("R12 ack level", 12'h010, 32'd60);
      rd_check("R12 held while active", 12'h204, 32'h0);
      wr(12'h014, 32'd60);
      rd_check("R12 re-pend after eoi", 12'h204, 32'h1000_0000);
      @(negedge clk); irq_lines[60] = 1'b0; irq_lines[61] = 1'b0;
      wr(12'h284, 32'h1000_0000);
      rd_check("R12 level dropped", 12'h204, 32'h0);
      @(negedge clk); irq_lines[61] = 1'b1;
      repeat (2) @(negedge clk);
      rd_check("R12 new edge", 12'h204, 32'h2000_0000);
      wr(12'h284, 32'h2000_0000);
      wr(12'h184, 32'h1000_0000);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enable();
      t_pend_regs();
      t_sgi();
      t_priority();
      t_bpr();
      t_active();
      t_level_edge();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule